// File: doc/BRIEF.md
# Serial Decimal-Digit to Binary Accumulator

This block turns a decimal number that arrives one digit at a time into its unsigned binary value. The digit of highest weight comes first. Each digit is a 4-bit BCD code, qualified by a send strobe. On every clock edge that carries a strobe, the running value is scaled by ten and the new digit is added to it. The scaling uses two shifted copies of the running value (times eight plus times two) fed into one adder. No general multiplier is used, so a digit costs exactly one clock.

A conversion starts with a synchronous reset, which clears the running value and the fault flag. The caller then strobes the digits in on consecutive or spaced clocks and reads the binary result. The result width is a parameter and defaults to 16 bits. A fault sets a flag that stays set until the next reset. A fault is either a digit code that is not decimal, or a step whose result would not fit in the result width. While the flag is set, later digits are refused and the result keeps its last good value.

Top module: `serial_bcd_to_bin`

## Requirements
- R1: On a clock edge with `send` high, no fault pending and a legal digit, `result` becomes the old `result` times ten plus `digit_in`. The new value can be read in the cycle after that edge.
- R2: Digits are taken most significant first. Strobing 1, 2, 3 yields 123 (binary 1111011), and leading zero digits leave the value unchanged.
- R3: On a clock edge with `send` low, `result` and `error` keep their values, whatever `digit_in` holds.
- R4: `rst` is synchronous and active high. After an edge with `rst` high, `result` is 0 and `error` is 0.
- R5: A strobed digit code from 10 to 15 sets `error` on that edge and leaves `result` unchanged.
- R6: A strobed digit whose result would exceed 2^16-1 (65535 at the default width) sets `error` and leaves `result` at its previous value. A step whose result is exactly 65535 is accepted without error.
- R7: Once `error` is set, it stays set until reset. Later strobed digits, legal or not, leave `result` unchanged.
- R8: Strobes on back-to-back clocks are each accepted, one digit per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset; clears result and error |
| digit_in | input | 4 | BCD digit to fold in; legal codes are 0 to 9 |
| send | input | 1 | Strobe; the digit is taken on an edge where this is high |
| result | output | 16 | Registered binary value built so far |
| error | output | 1 | Registered sticky fault flag (bad digit or overflow) |

## Verification
Both outputs come straight from registers. A digit strobed on one rising edge therefore shows up in `result`, or as a raised `error`, exactly one edge later, with no further pipeline stage. The bench drives `digit_in` and `send` on the falling edge and reads the outputs on the next falling edge. This places each check half a cycle after the single edge that should have acted. For refused strobes and idle cycles, the same next-falling-edge read confirms that `result` kept the value expected from the digits accepted before.

// File: rtl/bcd_ser_pkg.sv
package bcd_ser_pkg;
  localparam int DIGIT_W   = 4;
  localparam int DIGIT_MAX = 9;

  typedef enum logic [1:0] {
    STEP_IDLE  = 2'd0,
    STEP_LOAD  = 2'd1,
    STEP_FAULT = 2'd2
  } step_e;

  function automatic logic is_decimal(input logic [DIGIT_W-1:0] d);
    return (int'(d) <= DIGIT_MAX);
  endfunction
endpackage

// File: rtl/bcd_digit_check.sv
module bcd_digit_check
  import bcd_ser_pkg::*;
(
  input  logic [DIGIT_W-1:0] digit,
  output logic               legal
);
  always_comb legal = is_decimal(digit);
endmodule

// File: rtl/bcd_times_ten_add.sv
module bcd_times_ten_add
  import bcd_ser_pkg::*;
#(
  parameter int ACC_W = 16
) (
  input  logic [ACC_W-1:0]   acc,
  input  logic [DIGIT_W-1:0] digit,
  output logic [ACC_W-1:0]   sum,
  output logic               ovf
);
  // x10 fits in ACC_W+4 bits (below x16), and the +9 cannot carry past that
  localparam int WIDE_W = ACC_W + 4;

  logic [WIDE_W-1:0] ext;
  logic [WIDE_W-1:0] by8;
  logic [WIDE_W-1:0] by2;
  logic [WIDE_W-1:0] wide;

  always_comb begin
    ext  = WIDE_W'(acc);
    by8  = ext << 3;
    by2  = ext << 1;
    wide = by8 + by2 + WIDE_W'(digit);
    sum  = wide[ACC_W-1:0];
    ovf  = |wide[WIDE_W-1:ACC_W];
  end
endmodule

// File: rtl/bcd_accum_ctrl.sv
module bcd_accum_ctrl
  import bcd_ser_pkg::*;
#(
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             send,
  input  logic             digit_legal,
  input  logic [ACC_W-1:0] next_val,
  input  logic             next_ovf,
  output logic [ACC_W-1:0] acc_q,
  output logic             err_q
);
  step_e step;

  always_comb begin
    if (!send || err_q)              step = STEP_IDLE;
    else if (!digit_legal || next_ovf) step = STEP_FAULT;
    else                             step = STEP_LOAD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      err_q <= 1'b0;
    end else begin
      case (step)
        STEP_LOAD:  acc_q <= next_val;
        STEP_FAULT: err_q <= 1'b1;
        default: ;
      endcase
    end
  end

  // R4: reset clears both registers on the next edge
  assert_reset_clear_R4: assert property (@(posedge clk)
    rst |=> (acc_q == '0 && !err_q));

  // R3: no strobe, no change
  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !send |=> ($stable(acc_q) && $stable(err_q)));

  // R5: non-decimal code raises the flag and keeps the value
  assert_bad_digit_R5: assert property (@(posedge clk) disable iff (rst)
    (send && !err_q && !digit_legal) |=> (err_q && $stable(acc_q)));

  // R6: a step past the width faults instead of wrapping
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    (send && !err_q && next_ovf) |=> (err_q && $stable(acc_q)));

  // R7: flag is sticky and freezes the value
  assert_sticky_error_R7: assert property (@(posedge clk) disable iff (rst)
    err_q |=> (err_q && $stable(acc_q)));

  // R1: a good strobe loads the computed value
  assert_load_R1: assert property (@(posedge clk) disable iff (rst)
    (send && !err_q && digit_legal && !next_ovf) |=>
      (acc_q == $past(next_val) && !err_q));
endmodule

// File: rtl/serial_bcd_to_bin.sv
module serial_bcd_to_bin
  import bcd_ser_pkg::*;
#(
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       digit_in,
  input  logic             send,
  output logic [ACC_W-1:0] result,
  output logic             error
);
  logic             legal;
  logic [ACC_W-1:0] next_val;
  logic             next_ovf;
  logic [ACC_W-1:0] acc_q;
  logic             err_q;

  bcd_digit_check u_check (
    .digit (digit_in),
    .legal (legal)
  );

  bcd_times_ten_add #(.ACC_W(ACC_W)) u_mac (
    .acc   (acc_q),
    .digit (digit_in),
    .sum   (next_val),
    .ovf   (next_ovf)
  );

  bcd_accum_ctrl #(.ACC_W(ACC_W)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .send        (send),
    .digit_legal (legal),
    .next_val    (next_val),
    .next_ovf    (next_ovf),
    .acc_q       (acc_q),
    .err_q       (err_q)
  );

  assign result = acc_q;
  assign error  = err_q;
endmodule

// File: tb/serial_bcd_to_bin_test.sv
module serial_bcd_to_bin_test;
  logic        clk = 1'b0;
  logic        rst = 1'b0;
  logic [3:0]  digit_in = '0;
  logic        send = 1'b0;
  logic [15:0] result;
  logic        error;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  serial_bcd_to_bin uut (
    .clk(clk), .rst(rst), .digit_in(digit_in), .send(send),
    .result(result), .error(error)
  );

  // {send, digit, expected result, expected error}; walked right after reset
  localparam int NV = 12;
  localparam logic [21:0] VEC [NV] = '{
    {1'b1, 4'd1, 16'd1,     1'b0},  // R1
    {1'b1, 4'd2, 16'd12,    1'b0},  // R8
    {1'b1, 4'd3, 16'd123,   1'b0},  // R2
    {1'b0, 4'd7, 16'd123,   1'b0},  // R3
    {1'b0, 4'd12,16'd123,   1'b0},  // R3
    {1'b1, 4'd0, 16'd1230,  1'b0},  // R1
    {1'b1, 4'd9, 16'd12309, 1'b0},  // R8
    {1'b0, 4'd5, 16'd12309, 1'b0},  // R3
    {1'b1, 4'd0, 16'd0,     1'b0},  // placeholder overwritten below (reset row)
    {1'b1, 4'd0, 16'd0,     1'b0},  // R2 leading zero
    {1'b1, 4'd0, 16'd0,     1'b0},  // R2 leading zero
    {1'b1, 4'd7, 16'd7,     1'b0}   // R2
  };

  task automatic check(input string req, input logic [15:0] exp_v, input logic exp_e);
    checks++;
    if (result !== exp_v || error !== exp_e) begin
      fails++;
      $display("FAIL %s: result=%0d error=%0b expected result=%0d error=%0b",
               req, result, error, exp_v, exp_e);
    end
  endtask

  // called at a falling edge; outputs are read one full cycle later
  task automatic step(input logic s, input logic [3:0] d);
    send = s; digit_in = d;
    @(negedge clk);
    send = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; send = 1'b0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic feed(input logic [3:0] d);
    step(1'b1, d);
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    check("R4", 16'd0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      if (i == 8) begin
        do_reset();
        check("R4", 16'd0, 1'b0);
      end else begin
        step(VEC[i][21], VEC[i][20:17]);
        check("R1/R2/R3/R8 vector", VEC[i][16:1], VEC[i][0]);
      end
    end

    // exact upper bound accepted
    do_reset();
    feed(4'd6); feed(4'd5); feed(4'd5); feed(4'd3);
    check("R8", 16'd6553, 1'b0);
    feed(4'd5);
    check("R6 max", 16'd65535, 1'b0);

    // one past the bound
    do_reset();
    feed(4'd6); feed(4'd5); feed(4'd5); feed(4'd3); feed(4'd6);
    check("R6 overflow", 16'd6553, 1'b1);
    feed(4'd1);
    check("R7 ignored", 16'd6553, 1'b1);
    step(1'b0, 4'd0);
    check("R7 sticky", 16'd6553, 1'b1);
    do_reset();
    check("R4 clears error", 16'd0, 1'b0);

    // non-decimal codes
    feed(4'd10);
    check("R5 code 10", 16'd0, 1'b1);
    do_reset();
    feed(4'd4); feed(4'd15);
    check("R5 code 15", 16'd4, 1'b1);
    feed(4'd2);
    check("R7 after bad digit", 16'd4, 1'b1);

    // large overflow
    do_reset();
    feed(4'd9); feed(4'd9); feed(4'd9); feed(4'd9);
    check("R1", 16'd9999, 1'b0);
    feed(4'd9);
    check("R6 99999", 16'd9999, 1'b1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule